// File: doc/BRIEF.md
# Parallel Memory Write-Protection Guard

This block sits on the control side of a parallel nonvolatile memory and decides whether a bus write may start a program cycle. Writes to the array are often disturbed by supply ramps and noise on the control lines. The guard applies four filters before it lets a write through. The first is a lockout period after power-good rises. The second is a set of rules on the active-low chip enable, write enable and output enable pins. The third is a filter on the length of the low pulse. The last is a two-write unlock handshake at fixed addresses and data values.

Only after all four are satisfied does the next qualified bus write produce a single commit strobe. The strobe carries the captured address and data. Protection then re-arms by itself, so every program cycle needs a fresh unlock. A status output shows the window between a completed unlock and the commit that closes it. All timing is set in clock cycles by parameters. The bus pins are assumed to be already synchronous to the block clock.

Top module: `wpg_guard`

## Requirements
- R1: For POR_CYCLES clock cycles after pwr_good rises, no bus write is recognised. Such writes neither advance the unlock sequence nor produce a commit.
- R2: A write attempt during which oe_n is sampled low is ignored.
- R3: A write is attempted only while ce_n and we_n are both low. A pulse on we_n alone, with ce_n high, is ignored.
- R4: The pins must be sampled with both ce_n and we_n low for at least MIN_LOW consecutive cycles, or no write is recognised. A pulse of exactly MIN_LOW cycles is recognised. A pulse of MIN_LOW-1 cycles is not.
- R5: The unlock completes only after two recognised writes, in this order: data 0xAA to address 0x1555, then data 0x55 to address 0x0AAA.
- R6: If a recognised write does not match the expected unlock step, the sequencer returns to idle. The one exception is data 0xAA to address 0x1555, which restarts the sequence at its first step.
- R7: The first recognised write after a completed unlock raises commit for exactly one cycle. Protection then re-arms, so a following write produces no commit.
- R8: The commit carries the address and data sampled in the last cycle before ce_n or we_n rises, whichever of the two rises first.
- R9: A low level on pwr_good clears the sequencer to idle and restarts the lockout period of R1.
- R10: unlocked is high only from the completion of the unlock until the commit. It is low out of reset, and commit is low out of reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_good | input | 1 | Supply good indication |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Bus address |
| din | input | DATA_W | Bus write data |
| commit | output | 1 | One-cycle program strobe |
| commit_addr | output | ADDR_W | Address to program, valid with commit |
| commit_data | output | DATA_W | Data to program, valid with commit |
| unlocked | output | 1 | High while protection is disarmed |

## Verification
A sequencer stuck in the wrong step shows up on the ports within two cycles of the next recognised write. Either unlocked rises when it should not, or it fails to rise after the 0x55 step, or a commit appears or goes missing. A faulty pulse counter or lockout timer only becomes visible through those same outputs. For that reason the stimulus places writes just inside and just outside each timing window and then reads unlocked and the commit count. A fault in the capture registers shows only in commit_addr and commit_data, and only on the cycle of the commit.

// File: rtl/wpg_pkg.sv
// Package: shared types for the write-protection guard.
// Assumes: nothing beyond the standard language.
package wpg_pkg;
    // Steps of the unlock handshake
    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_STEP1 = 2'd1,
        SEQ_OPEN  = 2'd2
    } seq_state_t;
endpackage

// File: rtl/wpg_por_timer.sv
// Module: power-up lockout timer. Counts cycles from the rise of pwr_good.
// Reports por_ok once POR_CYCLES cycles have elapsed and pwr_good is still high.
// Assumes: pwr_good is synchronous to clk; POR_CYCLES >= 1.
module wpg_por_timer #(
    parameter int POR_CYCLES = 2_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_good,
    output logic por_ok
);
    localparam int CW = $clog2(POR_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(POR_CYCLES);

    logic [CW-1:0] cnt;

    // Restart on reset or supply loss, count up to the limit and hold there
    always_ff @(posedge clk) begin
        if (!rst_n || !pwr_good) begin
            cnt <= '0;
        end else if (cnt != LIMIT) begin
            cnt <= cnt + CW'(1);
        end
    end

    // Lockout has expired only while the supply stays good
    always_comb begin
        por_ok = pwr_good && (cnt == LIMIT);
    end
endmodule

// File: rtl/wpg_pulse_filter.sv
// Module: write-pulse qualifier. Counts consecutive cycles with ce_n and we_n
// both low, oe_n high and the lockout expired. When ce_n or we_n rises after at
// least MIN_LOW such cycles, it emits one recognised-write event carrying the
// address and data sampled in the last low cycle.
// Assumes: bus pins are synchronous to clk; MIN_LOW >= 1.
module wpg_pulse_filter #(
    parameter int ADDR_W  = 13,
    parameter int DATA_W  = 8,
    parameter int MIN_LOW = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_ok,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic              evt,
    output logic [ADDR_W-1:0] evt_addr,
    output logic [DATA_W-1:0] evt_data
);
    localparam int CW = $clog2(MIN_LOW + 1);
    localparam logic [CW-1:0] QUAL = CW'(MIN_LOW);

    logic [CW-1:0]     low_cnt;
    logic [ADDR_W-1:0] hold_addr;
    logic [DATA_W-1:0] hold_data;
    logic              active;
    logic              fire;

    // A cycle counts toward a write only with both strobes low and no inhibit
    always_comb begin
        active = !ce_n && !we_n && oe_n && por_ok;
        fire   = (low_cnt == QUAL) && (ce_n || we_n) && oe_n && por_ok;
    end

    // Saturating count of consecutive qualifying cycles
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            low_cnt <= '0;
        end else if (low_cnt != QUAL) begin
            low_cnt <= low_cnt + CW'(1);
        end
    end

    // Track the bus values of the most recent qualifying cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_addr <= '0;
            hold_data <= '0;
        end else if (active) begin
            hold_addr <= addr;
            hold_data <= din;
        end
    end

    // Emit a recognised-write event on the first rising strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt      <= 1'b0;
            evt_addr <= '0;
            evt_data <= '0;
        end else begin
            evt <= fire;
            if (fire) begin
                evt_addr <= hold_addr;
                evt_data <= hold_data;
            end
        end
    end
endmodule

// File: rtl/wpg_unlock_seq.sv
// Module: unlock sequencer. Walks the two-step handshake on recognised writes.
// Passes the first write after the handshake out as a one-cycle commit, then
// re-arms. Supply loss forces it back to idle.
// Assumes: evt is a single-cycle pulse from the pulse filter.
module wpg_unlock_seq
    import wpg_pkg::*;
#(
    parameter int              ADDR_W = 13,
    parameter int              DATA_W = 8,
    parameter logic [ADDR_W-1:0] KEY1_ADDR = 13'h1555,
    parameter logic [DATA_W-1:0] KEY1_DATA = 8'hAA,
    parameter logic [ADDR_W-1:0] KEY2_ADDR = 13'h0AAA,
    parameter logic [DATA_W-1:0] KEY2_DATA = 8'h55
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_good,
    input  logic              evt,
    input  logic [ADDR_W-1:0] evt_addr,
    input  logic [DATA_W-1:0] evt_data,
    output logic              commit,
    output logic [ADDR_W-1:0] commit_addr,
    output logic [DATA_W-1:0] commit_data,
    output logic              unlocked
);
    seq_state_t state, state_nx;
    logic       is_key1, is_key2, do_commit;

    // Decode the incoming write against both key steps
    always_comb begin
        is_key1 = (evt_addr == KEY1_ADDR) && (evt_data == KEY1_DATA);
        is_key2 = (evt_addr == KEY2_ADDR) && (evt_data == KEY2_DATA);
    end

    // Next-step selection for one recognised write
    always_comb begin
        state_nx  = state;
        do_commit = 1'b0;
        if (evt) begin
            unique case (state)
                SEQ_IDLE:  state_nx = is_key1 ? SEQ_STEP1 : SEQ_IDLE;
                SEQ_STEP1: state_nx = is_key2 ? SEQ_OPEN :
                                      (is_key1 ? SEQ_STEP1 : SEQ_IDLE);
                SEQ_OPEN: begin
                    state_nx  = SEQ_IDLE;
                    do_commit = 1'b1;
                end
                default:   state_nx = SEQ_IDLE;
            endcase
        end
    end

    // State register, cleared by reset or supply loss
    always_ff @(posedge clk) begin
        if (!rst_n || !pwr_good) begin
            state <= SEQ_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Commit strobe and its payload
    always_ff @(posedge clk) begin
        if (!rst_n || !pwr_good) begin
            commit      <= 1'b0;
            commit_addr <= '0;
            commit_data <= '0;
        end else begin
            commit <= do_commit;
            if (do_commit) begin
                commit_addr <= evt_addr;
                commit_data <= evt_data;
            end
        end
    end

    // Disarmed flag follows the open step
    always_comb begin
        unlocked = (state == SEQ_OPEN);
    end
endmodule

// File: rtl/wpg_guard.sv
// Module: top of the write-protection guard. Chains the lockout timer, the
// pulse qualifier and the unlock sequencer.
// Assumes: all inputs are synchronous to clk. POR_CYCLES and MIN_LOW are given
// in clock cycles (defaults: 10 ms and 15 ns at 200 MHz).
module wpg_guard #(
    parameter int ADDR_W     = 13,
    parameter int DATA_W     = 8,
    parameter int POR_CYCLES = 2_000_000,
    parameter int MIN_LOW    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_good,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic              commit,
    output logic [ADDR_W-1:0] commit_addr,
    output logic [DATA_W-1:0] commit_data,
    output logic              unlocked
);
    logic              por_ok;
    logic              evt;
    logic [ADDR_W-1:0] evt_addr;
    logic [DATA_W-1:0] evt_data;

    wpg_por_timer #(.POR_CYCLES(POR_CYCLES)) u_por (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .por_ok(por_ok)
    );

    wpg_pulse_filter #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MIN_LOW(MIN_LOW)) u_filt (
        .clk(clk), .rst_n(rst_n), .por_ok(por_ok),
        .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .addr(addr), .din(din),
        .evt(evt), .evt_addr(evt_addr), .evt_data(evt_data)
    );

    wpg_unlock_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good),
        .evt(evt), .evt_addr(evt_addr), .evt_data(evt_data),
        .commit(commit), .commit_addr(commit_addr), .commit_data(commit_data),
        .unlocked(unlocked)
    );
endmodule

// File: rtl/wpg_guard_chk.sv
// Module: assertion checker for wpg_guard, attached by the bind below.
// Assumes: connected to the top's ports and internal event/lockout nets.
module wpg_guard_chk (
    input logic clk,
    input logic rst_n,
    input logic pwr_good,
    input logic oe_n,
    input logic por_ok,
    input logic evt,
    input logic commit,
    input logic unlocked
);
    p_commit_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);

    p_commit_after_open_r10: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> $past(unlocked));

    p_commit_rearms_r7: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> !unlocked);

    p_supply_loss_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |=> (!unlocked && !commit));

    p_oe_inhibit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |=> !evt);

    p_lockout_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !por_ok |=> !evt);
endmodule

bind wpg_guard wpg_guard_chk u_chk (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .oe_n(oe_n),
    .por_ok(por_ok), .evt(evt), .commit(commit), .unlocked(unlocked)
);

// File: tb/tb_wpg_guard.sv
// Bench for wpg_guard: a vector table walked by one loop, then directed cases.
module tb_wpg_guard;
    localparam int AW = 13;
    localparam int DW = 8;
    localparam int POR = 50;
    localparam int MINL = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_good = 1'b0;
    logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic commit, unlocked;
    logic [AW-1:0] commit_addr;
    logic [DW-1:0] commit_data;

    int nchk = 0, nfail = 0, ncommit = 0;
    logic [AW-1:0] last_a = '0;
    logic [DW-1:0] last_d = '0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    wpg_guard #(.ADDR_W(AW), .DATA_W(DW), .POR_CYCLES(POR), .MIN_LOW(MINL)) dut (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .ce_n(ce_n), .we_n(we_n),
        .oe_n(oe_n), .addr(addr), .din(din), .commit(commit),
        .commit_addr(commit_addr), .commit_data(commit_data), .unlocked(unlocked)
    );

    // Count commit pulses away from the active edge
    always @(negedge clk) begin
        if (commit) begin
            ncommit++;
            last_a = commit_addr;
            last_d = commit_data;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One bus write: n low cycles, optional ce high (we-only) and oe level
    task automatic bus_wr(input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input int n, input bit ce_low, input logic oe);
        @(negedge clk);
        addr = a; din = d; we_n = 1'b0; ce_n = !ce_low; oe_n = oe;
        repeat (n) @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        bus_wr(a, d, MINL, 1'b1, 1'b1);
    endtask

    // Table: addr, data, low cycles, expected unlocked, expected commit
    localparam int NV = 16;
    localparam logic [26:0] VEC [0:NV-1] = '{
        {13'h1555, 8'hAA, 4'd3, 1'b0, 1'b0},  // R5 step one
        {13'h0AAA, 8'h55, 4'd3, 1'b1, 1'b0},  // R5 step two
        {13'h0100, 8'h12, 4'd3, 1'b0, 1'b1},  // R7 commit
        {13'h0101, 8'h34, 4'd3, 1'b0, 1'b0},  // R7 re-armed
        {13'h1555, 8'hAA, 4'd3, 1'b0, 1'b0},
        {13'h0AAA, 8'h55, 4'd2, 1'b0, 1'b0},  // R4 one short of minimum
        {13'h0AAA, 8'h55, 4'd3, 1'b1, 1'b0},  // R4 exactly minimum
        {13'h1FFF, 8'h5A, 4'd6, 1'b0, 1'b1},  // R4 long pulse commits
        {13'h1555, 8'hAA, 4'd3, 1'b0, 1'b0},
        {13'h0AAA, 8'h11, 4'd3, 1'b0, 1'b0},  // R6 wrong data -> idle
        {13'h0AAA, 8'h55, 4'd3, 1'b0, 1'b0},  // R6 step two alone fails
        {13'h1555, 8'hAA, 4'd3, 1'b0, 1'b0},
        {13'h1555, 8'hAA, 4'd3, 1'b0, 1'b0},  // R6 restart at step one
        {13'h0AAA, 8'h55, 4'd3, 1'b1, 1'b0},
        {13'h0222, 8'h77, 4'd3, 1'b0, 1'b1},
        {13'h0555, 8'hAA, 4'd3, 1'b0, 1'b0}   // R5 key data, wrong address
    };

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            nfail++;
            nchk++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        int c0;
        repeat (5) @(negedge clk);
        chk("R10 reset commit", {31'd0, commit}, 32'd0);
        chk("R10 reset unlocked", {31'd0, unlocked}, 32'd0);
        rst_n = 1'b1;
        pwr_good = 1'b1;

        // R1: writes inside the lockout window are not recognised
        c0 = ncommit;
        wr(13'h1555, 8'hAA);
        wr(13'h0AAA, 8'h55);
        chk("R1 lockout unlock", {31'd0, unlocked}, 32'd0);
        wr(13'h0100, 8'h99);
        chk("R1 lockout commit", ncommit - c0, 32'd0);
        repeat (POR + 10) @(negedge clk);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            logic [26:0] v;
            v = VEC[i];
            c0 = ncommit;
            bus_wr(v[26:14], v[13:6], int'(v[5:2]), 1'b1, 1'b1);
            chk("R5 R6 R10 unlocked", {31'd0, unlocked}, {31'd0, v[1]});
            chk("R7 commit count", ncommit - c0, {31'd0, v[0]});
            if (v[0]) begin
                chk("R8 commit addr", {19'd0, last_a}, {19'd0, v[26:14]});
                chk("R8 commit data", {24'd0, last_d}, {24'd0, v[13:6]});
            end
        end

        // R2: output enable low suppresses the first key write
        bus_wr(13'h1555, 8'hAA, MINL, 1'b1, 1'b0);
        wr(13'h0AAA, 8'h55);
        chk("R2 oe low ignored", {31'd0, unlocked}, 32'd0);

        // R3: write enable low with chip enable high is no write
        bus_wr(13'h1555, 8'hAA, MINL, 1'b0, 1'b1);
        wr(13'h0AAA, 8'h55);
        chk("R3 we only ignored", {31'd0, unlocked}, 32'd0);

        // R8: bus changes mid-pulse, we_n rises before ce_n
        wr(13'h1555, 8'hAA);
        wr(13'h0AAA, 8'h55);
        c0 = ncommit;
        @(negedge clk);
        addr = 13'h0010; din = 8'h01; ce_n = 1'b0; we_n = 1'b0;
        repeat (2) @(negedge clk);
        addr = 13'h0020; din = 8'h02;
        repeat (2) @(negedge clk);
        we_n = 1'b1;
        @(negedge clk);
        addr = 13'h0030; din = 8'h03;
        @(negedge clk);
        ce_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R8 first-rise commit", ncommit - c0, 32'd1);
        chk("R8 last-low addr", {19'd0, last_a}, 32'h0020);
        chk("R8 last-low data", {24'd0, last_d}, 32'h02);

        // R9: supply loss clears the sequence and restarts the lockout
        wr(13'h1555, 8'hAA);
        wr(13'h0AAA, 8'h55);
        chk("R9 open before drop", {31'd0, unlocked}, 32'd1);
        pwr_good = 1'b0;
        repeat (2) @(negedge clk);
        chk("R9 cleared on drop", {31'd0, unlocked}, 32'd0);
        pwr_good = 1'b1;
        wr(13'h1555, 8'hAA);
        wr(13'h0AAA, 8'h55);
        chk("R9 lockout restarted", {31'd0, unlocked}, 32'd0);
        repeat (POR + 10) @(negedge clk);
        wr(13'h1555, 8'hAA);
        wr(13'h0AAA, 8'h55);
        chk("R9 open after lockout", {31'd0, unlocked}, 32'd1);
        c0 = ncommit;
        wr(13'h0555, 8'h3C);
        chk("R9 commit after lockout", ncommit - c0, 32'd1);
        chk("R9 commit data", {24'd0, last_d}, 32'h3C);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule